// File: doc/BRIEF.md
# Per-Pin Event Decoder with Skew Calibration

This block sits in a per-pin waveform channel, between the stage that fetches events and the stage that places the physical edges. Each incoming event carries a 4-bit extended code and a time, given as a count of vernier units from the start of the period. The decoder turns the code into one of seven primitive pin actions. Codes that depend on the pattern data are resolved using the one or two functional data bits latched for the current vector.

In the same clock, the block looks up a signed skew correction in a small calibration RAM. The RAM is indexed by the resolved action and by the drive state the pin is leaving, so a rise from high-impedance can carry a different correction from a rise from low. The correction is added to the event time. A result below zero is clamped to zero and flagged. Software fills the RAM through a simple write port before the test runs.

The block is one pipeline stage deep. Its outputs are registered, and each event appears on them one clock after it is presented.

Top module: `evcal_decoder`

## Requirements
- R1: After synchronous reset, out_valid, out_time and out_clamp are 0, every calibration word is 0, and the tracked drive state is OFF (drive state encoding: 0 = LOW, 1 = HIGH, 2 = OFF).
- R2: Data-independent codes map to actions as follows. Code 0 gives DRV_LO, 1 gives DRV_HI, 6 gives DRV_OFF, 8 gives CMP_LO, 9 gives CMP_HI, 14 gives CMP_Z, and 15 and the spare code 7 give CMP_END. Action encoding: DRV_LO=0, DRV_HI=1, DRV_OFF=2, CMP_LO=3, CMP_HI=4, CMP_Z=5, CMP_END=6.
- R3: Data-dependent codes resolve against the latched bits. Code 2 drives bit 0 and code 3 drives bit 1, where a bit value of 1 gives DRV_HI and 0 gives DRV_LO. Codes 4 and 5 drive the inverse of bit 0 and bit 1. Codes 10 to 13 do the same for compares, giving CMP_HI for 1 and CMP_LO for 0.
- R4: vec_data is captured when vec_load is high and held until the next load. An event presented in the same cycle as a load still uses the bits held before that load.
- R5: When the DATA_BITS parameter is 1, the second-bit codes (3, 5, 11, 13) use bit 0.
- R6: The tracked drive state changes only on a valid DRV_LO, DRV_HI or DRV_OFF event. Compare actions and cycles with ev_valid low leave it unchanged. out_from reports the state that was in force before the event.
- R7: The calibration word is taken from RAM address action*4 + from_state. A cal_we write to cal_addr is used by every later event that resolves to that address.
- R8: out_time equals ev_time plus the signed calibration word. If the sum is negative, out_time is 0 and out_clamp is 1. A sum of exactly 0 is not flagged.
- R9: out_valid is ev_valid delayed by one clock, and the other outputs describe the event presented in that previous cycle.
- R10: When a write and an event that reads the same address happen in one cycle, the event uses the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_load | input | 1 | Latch vec_data for a new vector |
| vec_data | input | 2 | Functional data bits for the vector |
| ev_valid | input | 1 | Event present this cycle |
| ev_code | input | 4 | Extended event code |
| ev_time | input | TIME_W (10) | Event time in vernier units |
| cal_we | input | 1 | Calibration RAM write enable |
| cal_addr | input | 5 | Calibration word address {action, from-state} |
| cal_wdata | input | CAL_W (8) | Signed calibration word |
| out_valid | output | 1 | Decoded event valid |
| out_act | output | 3 | Primitive action |
| out_from | output | 2 | Drive state before this event |
| out_time | output | TIME_W+1 (11) | Calibrated time |
| out_clamp | output | 1 | Negative sum clamped to zero |

## Verification
The assertions assume that ev_code is always one of the sixteen defined values. They also assume that cal_addr points at a real action slot, meaning the action field is not 7 and the state field is not 3. The stimulus writes calibration words only to addresses built as action*4 + state. Because the code input is four bits wide, every code it can carry is one the decoder defines. Drive events are sequenced so that every from-state is reached before the calibration paths that depend on it are checked.

// File: rtl/evcal_pkg.sv
package evcal_pkg;

    localparam int ACT_W = 3;
    localparam int DS_W  = 2;
    localparam int CODE_W = 4;

    typedef enum logic [ACT_W-1:0] {
        ACT_DRV_LO  = 3'd0,
        ACT_DRV_HI  = 3'd1,
        ACT_DRV_OFF = 3'd2,
        ACT_CMP_LO  = 3'd3,
        ACT_CMP_HI  = 3'd4,
        ACT_CMP_Z   = 3'd5,
        ACT_CMP_END = 3'd6
    } act_e;

    typedef enum logic [DS_W-1:0] {
        DS_LOW  = 2'd0,
        DS_HIGH = 2'd1,
        DS_OFF  = 2'd2
    } dstate_e;

    typedef enum logic [CODE_W-1:0] {
        EC_DRV_0   = 4'd0,
        EC_DRV_1   = 4'd1,
        EC_DRV_A   = 4'd2,
        EC_DRV_B   = 4'd3,
        EC_DRV_AN  = 4'd4,
        EC_DRV_BN  = 4'd5,
        EC_DRV_OFF = 4'd6,
        EC_SPARE   = 4'd7,
        EC_CMP_0   = 4'd8,
        EC_CMP_1   = 4'd9,
        EC_CMP_A   = 4'd10,
        EC_CMP_B   = 4'd11,
        EC_CMP_AN  = 4'd12,
        EC_CMP_BN  = 4'd13,
        EC_CMP_Z   = 4'd14,
        EC_CMP_END = 4'd15
    } ecode_e;

    function automatic logic act_is_drive(act_e a);
        return (a == ACT_DRV_LO) || (a == ACT_DRV_HI) || (a == ACT_DRV_OFF);
    endfunction

    function automatic dstate_e drive_target(act_e a);
        case (a)
            ACT_DRV_LO: return DS_LOW;
            ACT_DRV_HI: return DS_HIGH;
            default:    return DS_OFF;
        endcase
    endfunction

endpackage

// File: rtl/evcal_decode.sv
module evcal_decode
    import evcal_pkg::*;
#(
    parameter int DATA_BITS = 2
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic [1:0]        data_i,
    output act_e              act_o,
    output logic              is_drive_o
);
    logic bit_a;
    logic bit_b;

    assign bit_a = data_i[0];

    generate
        if (DATA_BITS == 1) begin : g_one_bit
            assign bit_b = data_i[0];
        end else begin : g_two_bit
            assign bit_b = data_i[1];
        end
    endgenerate

    always_comb begin
        case (ecode_e'(code_i))
            EC_DRV_0:   act_o = ACT_DRV_LO;
            EC_DRV_1:   act_o = ACT_DRV_HI;
            EC_DRV_A:   act_o = bit_a ? ACT_DRV_HI : ACT_DRV_LO;
            EC_DRV_B:   act_o = bit_b ? ACT_DRV_HI : ACT_DRV_LO;
            EC_DRV_AN:  act_o = bit_a ? ACT_DRV_LO : ACT_DRV_HI;
            EC_DRV_BN:  act_o = bit_b ? ACT_DRV_LO : ACT_DRV_HI;
            EC_DRV_OFF: act_o = ACT_DRV_OFF;
            EC_CMP_0:   act_o = ACT_CMP_LO;
            EC_CMP_1:   act_o = ACT_CMP_HI;
            EC_CMP_A:   act_o = bit_a ? ACT_CMP_HI : ACT_CMP_LO;
            EC_CMP_B:   act_o = bit_b ? ACT_CMP_HI : ACT_CMP_LO;
            EC_CMP_AN:  act_o = bit_a ? ACT_CMP_LO : ACT_CMP_HI;
            EC_CMP_BN:  act_o = bit_b ? ACT_CMP_LO : ACT_CMP_HI;
            EC_CMP_Z:   act_o = ACT_CMP_Z;
            default:    act_o = ACT_CMP_END;
        endcase
    end

    assign is_drive_o = act_is_drive(act_o);

endmodule

// File: rtl/evcal_cal_ram.sv
module evcal_cal_ram #(
    parameter int ADDR_W = 5,
    parameter int CAL_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [CAL_W-1:0]  wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [CAL_W-1:0]  rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [CAL_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/evcal_time_adj.sv
module evcal_time_adj #(
    parameter int TIME_W = 10,
    parameter int CAL_W  = 8
) (
    input  logic [TIME_W-1:0] time_i,
    input  logic [CAL_W-1:0]  off_i,
    output logic [TIME_W:0]   time_o,
    output logic              clamp_o
);
    localparam int SUM_W = TIME_W + 2;

    logic [SUM_W-1:0] sum;

    assign sum = {2'b00, time_i} + {{(SUM_W-CAL_W){off_i[CAL_W-1]}}, off_i};

    always_comb begin
        if (sum[SUM_W-1]) begin
            time_o  = '0;
            clamp_o = 1'b1;
        end else begin
            time_o  = sum[TIME_W:0];
            clamp_o = 1'b0;
        end
    end

endmodule

// File: rtl/evcal_decoder.sv
module evcal_decoder
    import evcal_pkg::*;
#(
    parameter int DATA_BITS = 2,
    parameter int TIME_W    = 10,
    parameter int CAL_W     = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     vec_load,
    input  logic [1:0]               vec_data,
    input  logic                     ev_valid,
    input  logic [CODE_W-1:0]        ev_code,
    input  logic [TIME_W-1:0]        ev_time,
    input  logic                     cal_we,
    input  logic [ACT_W+DS_W-1:0]    cal_addr,
    input  logic [CAL_W-1:0]         cal_wdata,
    output logic                     out_valid,
    output logic [ACT_W-1:0]         out_act,
    output logic [DS_W-1:0]          out_from,
    output logic [TIME_W:0]          out_time,
    output logic                     out_clamp
);
    localparam int ADDR_W = ACT_W + DS_W;

    logic [1:0]       data_q;
    dstate_e          ds_q;
    act_e             dec_act;
    logic             dec_drive;
    logic [CAL_W-1:0] cal_word;
    logic [TIME_W:0]  adj_time;
    logic             adj_clamp;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (vec_load) begin
            data_q <= vec_data;
        end
    end

    evcal_decode #(.DATA_BITS(DATA_BITS)) u_decode (
        .code_i     (ev_code),
        .data_i     (data_q),
        .act_o      (dec_act),
        .is_drive_o (dec_drive)
    );

    evcal_cal_ram #(.ADDR_W(ADDR_W), .CAL_W(CAL_W)) u_cal (
        .clk     (clk),
        .rst     (rst),
        .we_i    (cal_we),
        .waddr_i (cal_addr),
        .wdata_i (cal_wdata),
        .raddr_i ({dec_act, ds_q}),
        .rdata_o (cal_word)
    );

    evcal_time_adj #(.TIME_W(TIME_W), .CAL_W(CAL_W)) u_adj (
        .time_i  (ev_time),
        .off_i   (cal_word),
        .time_o  (adj_time),
        .clamp_o (adj_clamp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ds_q <= DS_OFF;
        end else if (ev_valid && dec_drive) begin
            ds_q <= drive_target(dec_act);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_act   <= '0;
            out_from  <= DS_OFF;
            out_time  <= '0;
            out_clamp <= 1'b0;
        end else begin
            out_valid <= ev_valid;
            if (ev_valid) begin
                out_act   <= dec_act;
                out_from  <= ds_q;
                out_time  <= adj_time;
                out_clamp <= adj_clamp;
            end
        end
    end

    // R9: the output valid is the input valid one clock later
    a_r9_valid_rise: assert property (@(posedge clk) disable iff (rst)
        ev_valid |=> out_valid);
    a_r9_valid_idle: assert property (@(posedge clk) disable iff (rst)
        !ev_valid |=> !out_valid);

    // R2: no event ever produces the unused action slot
    a_r2_act_legal: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_act != 3'd7));

    // R6: the tracked state moves only after a valid drive-class event
    a_r6_state_hold: assert property (@(posedge clk) disable iff (rst)
        !(ev_valid && dec_drive) |=> $stable(ds_q));

    // R6: the reported from-state is always a legal encoding
    a_r6_from_legal: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_from != 2'd3));

    // R8: a clamped result always reads zero
    a_r8_clamp_zero: assert property (@(posedge clk) disable iff (rst)
        out_clamp |-> (out_time == '0));

    // R8: a non-negative offset never shortens the event time
    a_r8_no_shrink: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && !cal_word[CAL_W-1]) |=> (out_time >= {1'b0, $past(ev_time)}));

endmodule

// File: tb/evcal_decoder_tb.sv
module evcal_decoder_tb;
    localparam int TIME_W = 10;
    localparam int CAL_W  = 8;

    logic        clk = 1'b0;
    logic        rst;
    logic        vec_load;
    logic [1:0]  vec_data;
    logic        ev_valid;
    logic [3:0]  ev_code;
    logic [TIME_W-1:0] ev_time;
    logic        cal_we;
    logic [4:0]  cal_addr;
    logic [CAL_W-1:0] cal_wdata;
    logic        out_valid, out_clamp;
    logic [2:0]  out_act;
    logic [1:0]  out_from;
    logic [TIME_W:0] out_time;
    logic        v1, c1;
    logic [2:0]  a1;
    logic [1:0]  f1;
    logic [TIME_W:0] t1;

    int total = 0;
    int bad   = 0;
    int cal_m [32];
    int ds_m;
    logic [1:0] data_m;
    int exp1_act;

    always #10 clk = ~clk;

    evcal_decoder #(.DATA_BITS(2), .TIME_W(TIME_W), .CAL_W(CAL_W)) u_dut (
        .clk(clk), .rst(rst), .vec_load(vec_load), .vec_data(vec_data),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_time(ev_time),
        .cal_we(cal_we), .cal_addr(cal_addr), .cal_wdata(cal_wdata),
        .out_valid(out_valid), .out_act(out_act), .out_from(out_from),
        .out_time(out_time), .out_clamp(out_clamp));

    evcal_decoder #(.DATA_BITS(1), .TIME_W(TIME_W), .CAL_W(CAL_W)) u_dut1 (
        .clk(clk), .rst(rst), .vec_load(vec_load), .vec_data(vec_data),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_time(ev_time),
        .cal_we(cal_we), .cal_addr(cal_addr), .cal_wdata(cal_wdata),
        .out_valid(v1), .out_act(a1), .out_from(f1),
        .out_time(t1), .out_clamp(c1));

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int model_act(input int code, input logic [1:0] d, input int nbits);
        logic a, b;
        a = d[0];
        b = (nbits == 1) ? d[0] : d[1];
        case (code)
            0: return 0;
            1: return 1;
            2: return a ? 1 : 0;
            3: return b ? 1 : 0;
            4: return a ? 0 : 1;
            5: return b ? 0 : 1;
            6: return 2;
            8: return 3;
            9: return 4;
            10: return a ? 4 : 3;
            11: return b ? 4 : 3;
            12: return a ? 3 : 4;
            13: return b ? 3 : 4;
            14: return 5;
            default: return 6;
        endcase
    endfunction

    task automatic idle_inputs();
        vec_load = 0; vec_data = 0; ev_valid = 0; ev_code = 0; ev_time = 0;
        cal_we = 0; cal_addr = 0; cal_wdata = 0;
    endtask

    // one event, optionally with a same-cycle write and/or vector load
    task automatic send(input int code, input int t, input bit we, input int wa,
                        input int wd, input bit ld, input logic [1:0] ldv, input string tag);
        int act, from, sum, et, ec;
        @(negedge clk);
        ev_valid = 1; ev_code = code[3:0]; ev_time = t[TIME_W-1:0];
        cal_we = we; cal_addr = wa[4:0]; cal_wdata = wd[CAL_W-1:0];
        vec_load = ld; vec_data = ldv;
        act  = model_act(code, data_m, 2);
        exp1_act = model_act(code, data_m, 1);
        from = ds_m;
        sum  = t + cal_m[act*4 + from];
        et   = (sum < 0) ? 0 : sum;
        ec   = (sum < 0) ? 1 : 0;
        @(negedge clk);
        idle_inputs();
        chk({tag, " valid"}, out_valid, 1);
        chk({tag, " act"},   out_act, act);
        chk({tag, " from"},  out_from, from);
        chk({tag, " time"},  out_time, et);
        chk({tag, " clamp"}, out_clamp, ec);
        if (act <= 2) ds_m = act;
        if (we) cal_m[wa] = wd;
        if (ld) data_m = ldv;
    endtask

    task automatic ev(input int code, input int t, input string tag);
        send(code, t, 0, 0, 0, 0, 2'b00, tag);
    endtask

    task automatic wr(input int addr, input int val);
        @(negedge clk);
        cal_we = 1; cal_addr = addr[4:0]; cal_wdata = val[CAL_W-1:0];
        @(negedge clk);
        idle_inputs();
        cal_m[addr] = val;
    endtask

    task automatic load(input logic [1:0] d);
        @(negedge clk);
        vec_load = 1; vec_data = d;
        @(negedge clk);
        idle_inputs();
        data_m = d;
    endtask

    task automatic t_reset();
        rst = 1;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 0;
        foreach (cal_m[i]) cal_m[i] = 0;
        ds_m = 2; data_m = 2'b00;
        @(negedge clk);
        chk("R1 reset valid", out_valid, 0);
        chk("R1 reset time",  out_time, 0);
        chk("R1 reset clamp", out_clamp, 0);
        ev(15, 10, "R1 first from OFF");
    endtask

    task automatic t_fixed();
        ev(0, 11, "R2 code0");
        ev(1, 12, "R2 code1");
        ev(6, 13, "R2 code6");
        ev(8, 14, "R2 code8");
        ev(9, 15, "R2 code9");
        ev(14, 16, "R2 code14");
        ev(15, 17, "R2 code15");
        ev(7, 18, "R2 spare7");
    endtask

    task automatic t_data();
        load(2'b01);
        for (int c = 2; c <= 5; c++) ev(c, 30 + c, "R3 drive d=01");
        for (int c = 10; c <= 13; c++) ev(c, 30 + c, "R3 cmp d=01");
        load(2'b10);
        for (int c = 2; c <= 5; c++) ev(c, 40 + c, "R3 drive d=10");
        for (int c = 10; c <= 13; c++) ev(c, 40 + c, "R3 cmp d=10");
        load(2'b01);
        send(2, 50, 0, 0, 0, 1, 2'b10, "R4 load same cycle");
        ev(2, 51, "R4 new data held");
        repeat (2) @(negedge clk);
        ev(3, 52, "R4 still held");
    endtask

    task automatic t_single();
        load(2'b01);
        ev(3, 60, "R5 pair");
        chk("R5 one-bit code3", a1, exp1_act);
        ev(5, 61, "R5 pair");
        chk("R5 one-bit code5", a1, exp1_act);
        load(2'b10);
        ev(11, 62, "R5 pair");
        chk("R5 one-bit code11", a1, exp1_act);
        ev(13, 63, "R5 pair");
        chk("R5 one-bit code13", a1, exp1_act);
    endtask

    task automatic t_state();
        ev(0, 70, "R6 drive low");
        ev(9, 71, "R6 compare keeps");
        ev(14, 72, "R6 compare z keeps");
        @(negedge clk);
        ev_valid = 0; ev_code = 4'd1; ev_time = 10'd73;
        @(negedge clk);
        idle_inputs();
        chk("R9 no valid out", out_valid, 0);
        ev(15, 74, "R6 invalid ignored");
        ev(6, 75, "R6 drive off");
        ev(1, 76, "R6 high from off");
    endtask

    task automatic t_cal();
        wr(1*4 + 2, 5);
        wr(1*4 + 0, -3);
        wr(4*4 + 1, 9);
        ev(6, 100, "R7 to off");
        ev(1, 100, "R7 high from off +5");
        ev(9, 200, "R7 cmp hi from high +9");
        ev(0, 100, "R7 to low");
        ev(1, 100, "R7 high from low -3");
    endtask

    task automatic t_clamp();
        wr(0*4 + 1, -20);
        ev(1, 5, "R8 to high");
        ev(0, 7, "R8 negative clamps");
        ev(1, 5, "R8 back high");
        ev(0, 20, "R8 exact zero");
        ev(1, 5, "R8 back high");
        ev(0, 1023, "R8 large time");
    endtask

    task automatic t_same();
        // state is LOW here; CMP_END from LOW is address 6*4+0
        send(15, 300, 1, 6*4 + 0, 40, 0, 2'b00, "R10 write same cycle");
        ev(15, 300, "R10 next sees new");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_fixed();
        t_data();
        t_single();
        t_state();
        t_cal();
        t_clamp();
        t_same();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule